// File: doc/BRIEF.md
# Byte-Lane Steering for Narrow Devices on a 16-bit Bus

This block lets an 8-bit peripheral wired only to the low byte lane sit inside a 16-bit external bus region. On a byte access to an odd address, the processor puts the byte on bits 15..8. An 8-bit device on bits 7..0 would never see that byte, and could never return one.

At the start of each access the block samples an active-low width signal from the device. If that access needs fixing, it crosses the byte between the lanes:

- **Write:** the upper CPU byte is copied down to the device's low lanes.
- **Read:** the device's low byte is mirrored up to the CPU's upper lanes.

A 16-bit access is never split into two byte cycles. The steering only reroutes lanes inside the single cycle the processor already runs.

**Enables.** Steering is allowed per chip select. Each of the five chip selects has an effective enable, formed as the OR of one global enable and that select's own enable bit. On selects that support card-timing mode (by default the fourth and fifth), an active card mode suppresses steering on that select. The routing decision and the data muxing are kept apart: a small control FSM latches a per-access decision, and a combinational datapath acts on it while a strobe is low.

Top module: `byte_lane_steer`

## Requirements
- R1: After reset, with no access in progress, both steering flags are 0 and both data paths pass straight through (devWrData equals cpuWrData, cpuRdData equals devRdData).
- R2: The effective enable for chip select k (csN bit k-1 for selects 1 to 5) is globalEn OR csEn bit k-1. The enable bits of other chip selects have no effect on an access to select k.
- R3: For a select whose CARD_MASK bit is set (bits 3 and 4 by default, i.e. selects 4 and 5), a set cardMode bit for that select suppresses steering even when enabled. cardMode bits of selects outside CARD_MASK, or of other selects, have no effect.
- R4: widthN is active low. 0 means an 8-bit device and allows steering; 1 means a 16-bit device and forces straight pass-through.
- R5: During a steered write (weN low), devWrData[7:0] equals cpuWrData[15:8], devWrData[15:8] equals cpuWrData[15:8], and steerWr is 1.
- R6: During a steered read (oeN low), cpuRdData[15:8] and cpuRdData[7:0] both equal devRdData[7:0], and steerRd is 1.
- R7: An access with addr0 = 0 is never steered.
- R8: The decision is taken at the first rising clock edge where some csN bit is low and both strobes are high. Later changes to widthN, addr0, globalEn, csEn or cardMode have no effect until every csN bit has been high at a clock edge.
- R9: If a strobe is already low at the first clock edge that sees a chip select low, that access is not steered.
- R10: steerWr is 1 only while weN is low; steerRd is 1 only while oeN is low. There is no splitting into a second cycle.
- R11: If several csN bits are low together, the lowest-numbered one decides enable and card-mode gating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 5 | Chip selects 1..5, active low, bit 0 = select 1 |
| addr0 | input | 1 | Address bit 0 |
| oeN | input | 1 | Read strobe, active low |
| weN | input | 1 | Write strobe, active low |
| widthN | input | 1 | Device width, 0 = 8-bit device |
| globalEn | input | 1 | Global steering enable |
| csEn | input | 5 | Per-select steering enables |
| cardMode | input | 5 | Card-timing mode active, per select |
| cpuWrData | input | 16 | Write data from the CPU |
| devRdData | input | 16 | Read data from the device |
| devWrData | output | 16 | Write data routed to the device |
| cpuRdData | output | 16 | Read data routed to the CPU |
| steerWr | output | 1 | Write lanes crossed this cycle |
| steerRd | output | 1 | Read lanes crossed this cycle |

## Verification
The bench sweeps every chip select against all combinations of global enable, own enable, own card mode, width and addr0, for both reads and writes. In each case it sets the other selects' enable and card bits to the opposite value. This catches a design that indexes the wrong enable, mixes selects, or gates card mode on selects 1 to 3.

Directed accesses then change width, address and enables after the decision edge; a design that reads them live would flip its routing in mid-cycle. Further cases cover:
- a strobe that is already low when the select arrives, which a design that samples too late would wrongly steer;
- overlapping selects, which expose a wrong priority order.

// File: rtl/lane_pkg.sv
package lane_pkg;

  // Strobes from the control FSM to the lane datapath
  typedef struct packed {
    logic wrSwap;
    logic rdSwap;
  } lane_ctl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_OPEN = 1'b1
  } access_st_t;

endpackage

// File: rtl/lane_enable.sv
module lane_enable #(
  parameter int NUM_CS = 5,
  parameter logic [NUM_CS-1:0] CARD_MASK = 5'b11000
) (
  input  logic              globalEn,
  input  logic [NUM_CS-1:0] csEn,
  input  logic [NUM_CS-1:0] cardMode,
  output logic [NUM_CS-1:0] effEn
);

  for (genvar k = 0; k < NUM_CS; k++) begin : gEn
    if (CARD_MASK[k]) begin : gCard
      assign effEn[k] = (globalEn | csEn[k]) & ~cardMode[k];
    end else begin : gPlain
      assign effEn[k] = globalEn | csEn[k];
    end
  end

endmodule

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lane_pkg::*;
#(
  parameter int NUM_CS = 5,
  parameter logic [NUM_CS-1:0] CARD_MASK = 5'b11000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CS-1:0] csN,
  input  logic              addr0,
  input  logic              oeN,
  input  logic              weN,
  input  logic              widthN,
  input  logic              globalEn,
  input  logic [NUM_CS-1:0] csEn,
  input  logic [NUM_CS-1:0] cardMode,
  output lane_ctl_t         ctl
);

  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic [NUM_CS-1:0] effEn;
  logic [IDX_W-1:0]  selIdx;
  logic              csAny;
  logic              strobesIdle;
  logic              wantSteer;
  access_st_t        state;
  logic              steerHeld;

  lane_enable #(
    .NUM_CS   (NUM_CS),
    .CARD_MASK(CARD_MASK)
  ) uEnable (
    .globalEn(globalEn),
    .csEn    (csEn),
    .cardMode(cardMode),
    .effEn   (effEn)
  );

  // Lowest-numbered asserted select wins
  always_comb begin
    selIdx = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (!csN[i]) selIdx = i[IDX_W-1:0];
    end
  end

  assign csAny       = ~(&csN);
  assign strobesIdle = oeN & weN;
  assign wantSteer   = effEn[selIdx] & ~widthN & addr0 & strobesIdle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      steerHeld <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (csAny) begin
            state     <= ST_OPEN;
            steerHeld <= wantSteer;
          end
        end
        ST_OPEN: begin
          if (!csAny) begin
            state     <= ST_IDLE;
            steerHeld <= 1'b0;
          end
        end
        default: begin
          state     <= ST_IDLE;
          steerHeld <= 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    ctl.wrSwap = steerHeld & (state == ST_OPEN) & csAny & ~weN;
    ctl.rdSwap = steerHeld & (state == ST_OPEN) & csAny & ~oeN;
  end

endmodule

// File: rtl/lane_datapath.sv
module lane_datapath
  import lane_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  lane_ctl_t          ctl,
  input  logic [DATA_W-1:0]  cpuWrData,
  input  logic [DATA_W-1:0]  devRdData,
  output logic [DATA_W-1:0]  devWrData,
  output logic [DATA_W-1:0]  cpuRdData
);

  localparam int LANE_W = DATA_W / 2;

  logic [LANE_W-1:0] cpuHigh;
  logic [LANE_W-1:0] devLow;

  assign cpuHigh = cpuWrData[DATA_W-1:LANE_W];
  assign devLow  = devRdData[LANE_W-1:0];

  always_comb begin
    devWrData = ctl.wrSwap ? {cpuHigh, cpuHigh} : cpuWrData;
    cpuRdData = ctl.rdSwap ? {devLow, devLow} : devRdData;
  end

endmodule

// File: rtl/byte_lane_steer.sv
module byte_lane_steer
  import lane_pkg::*;
#(
  parameter int NUM_CS = 5,
  parameter int DATA_W = 16,
  parameter logic [NUM_CS-1:0] CARD_MASK = 5'b11000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CS-1:0] csN,
  input  logic              addr0,
  input  logic              oeN,
  input  logic              weN,
  input  logic              widthN,
  input  logic              globalEn,
  input  logic [NUM_CS-1:0] csEn,
  input  logic [NUM_CS-1:0] cardMode,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] devRdData,
  output logic [DATA_W-1:0] devWrData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              steerWr,
  output logic              steerRd
);

  lane_ctl_t ctl;

  lane_ctrl #(
    .NUM_CS   (NUM_CS),
    .CARD_MASK(CARD_MASK)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .addr0   (addr0),
    .oeN     (oeN),
    .weN     (weN),
    .widthN  (widthN),
    .globalEn(globalEn),
    .csEn    (csEn),
    .cardMode(cardMode),
    .ctl     (ctl)
  );

  lane_datapath #(
    .DATA_W(DATA_W)
  ) uData (
    .ctl      (ctl),
    .cpuWrData(cpuWrData),
    .devRdData(devRdData),
    .devWrData(devWrData),
    .cpuRdData(cpuRdData)
  );

  assign steerWr = ctl.wrSwap;
  assign steerRd = ctl.rdSwap;

endmodule

// File: rtl/lane_checker.sv
module lane_checker #(
  parameter int NUM_CS = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CS-1:0] csN,
  input logic              oeN,
  input logic              weN,
  input logic [DATA_W-1:0] cpuWrData,
  input logic [DATA_W-1:0] devRdData,
  input logic [DATA_W-1:0] devWrData,
  input logic [DATA_W-1:0] cpuRdData,
  input logic              steerWr,
  input logic              steerRd
);

  localparam int LANE_W = DATA_W / 2;

  AST_WR_LOW_LANE: assert property (@(posedge clk) disable iff (!rstN)
    steerWr |-> devWrData[LANE_W-1:0] == cpuWrData[DATA_W-1:LANE_W]); // R5

  AST_WR_HIGH_LANE: assert property (@(posedge clk) disable iff (!rstN)
    steerWr |-> devWrData[DATA_W-1:LANE_W] == cpuWrData[DATA_W-1:LANE_W]); // R5

  AST_RD_HIGH_LANE: assert property (@(posedge clk) disable iff (!rstN)
    steerRd |-> cpuRdData[DATA_W-1:LANE_W] == devRdData[LANE_W-1:0]); // R6

  AST_WR_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !steerWr |-> devWrData == cpuWrData); // R7

  AST_RD_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !steerRd |-> cpuRdData == devRdData); // R7

  AST_WR_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    steerWr |-> !weN); // R10

  AST_RD_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    steerRd |-> !oeN); // R10

  AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (steerWr || steerRd) |-> !(&$past(csN))); // R8

endmodule

bind byte_lane_steer lane_checker #(
  .NUM_CS(NUM_CS),
  .DATA_W(DATA_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .oeN      (oeN),
  .weN      (weN),
  .cpuWrData(cpuWrData),
  .devRdData(devRdData),
  .devWrData(devWrData),
  .cpuRdData(cpuRdData),
  .steerWr  (steerWr),
  .steerRd  (steerRd)
);

// File: tb/sim_byte_lane_steer.sv
`timescale 1ns/1ps
module sim_byte_lane_steer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  csN = '1;
  logic        addr0 = 1'b0;
  logic        oeN = 1'b1;
  logic        weN = 1'b1;
  logic        widthN = 1'b1;
  logic        globalEn = 1'b0;
  logic [4:0]  csEn = '0;
  logic [4:0]  cardMode = '0;
  logic [15:0] cpuWrData = '0;
  logic [15:0] devRdData = '0;
  logic [15:0] devWrData;
  logic [15:0] cpuRdData;
  logic        steerWr;
  logic        steerRd;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  byte_lane_steer u0 (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .addr0    (addr0),
    .oeN      (oeN),
    .weN      (weN),
    .widthN   (widthN),
    .globalEn (globalEn),
    .csEn     (csEn),
    .cardMode (cardMode),
    .cpuWrData(cpuWrData),
    .devRdData(devRdData),
    .devWrData(devWrData),
    .cpuRdData(cpuRdData),
    .steerWr  (steerWr),
    .steerRd  (steerRd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkWrite(input string req, input logic [15:0] wd, input logic expSteer);
    check(req, {31'd0, steerWr}, {31'd0, expSteer});
    check(req, {16'd0, devWrData}, {16'd0, expSteer ? {wd[15:8], wd[15:8]} : wd});
  endtask

  task automatic checkRead(input string req, input logic [15:0] rd, input logic expSteer);
    check(req, {31'd0, steerRd}, {31'd0, expSteer});
    check(req, {16'd0, cpuRdData}, {16'd0, expSteer ? {rd[7:0], rd[7:0]} : rd});
  endtask

  task automatic endAccess();
    @(negedge clk);
    oeN = 1'b1; weN = 1'b1; csN = '1;
    @(negedge clk);
  endtask

  task automatic access(input logic [4:0] selN, input logic g, input logic [4:0] en,
                        input logic [4:0] card, input logic w, input logic a0,
                        input logic isWr, input logic [15:0] wd, input logic [15:0] rd,
                        input logic expSteer, input string req);
    @(negedge clk);
    globalEn = g; csEn = en; cardMode = card; widthN = w; addr0 = a0;
    cpuWrData = wd; devRdData = rd; csN = selN;
    @(negedge clk);
    if (isWr) weN = 1'b0; else oeN = 1'b0;
    #1;
    if (isWr) checkWrite(req, wd, expSteer);
    else      checkRead(req, rd, expSteer);
    endAccess();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: idle after reset, strobes low without any select
    cpuWrData = 16'hBEEF; devRdData = 16'h1234; oeN = 1'b0; weN = 1'b0;
    globalEn = 1'b1; widthN = 1'b0; addr0 = 1'b1;
    #1;
    checkWrite("R1 reset idle write", 16'hBEEF, 1'b0);
    checkRead("R1 reset idle read", 16'h1234, 1'b0);
    @(negedge clk);
    oeN = 1'b1; weN = 1'b1;

    // R2 R3 R4 R5 R6 R7: exhaustive sweep
    for (int cs = 0; cs < 5; cs++)
      for (int g = 0; g < 2; g++)
        for (int e = 0; e < 2; e++)
          for (int c = 0; c < 2; c++)
            for (int w = 0; w < 2; w++)
              for (int a = 0; a < 2; a++)
                for (int rw = 0; rw < 2; rw++) begin
                  logic [4:0] own;
                  logic [4:0] enV;
                  logic [4:0] cardV;
                  logic       eff;
                  logic       exp;
                  logic [15:0] wd;
                  logic [15:0] rd;
                  own   = 5'b1 << cs;
                  enV   = (e != 0) ? own : (~own);
                  cardV = (c != 0) ? own : (~own);
                  eff   = ((g != 0) || (e != 0)) && !((c != 0) && (cs >= 3));
                  exp   = eff && (w == 0) && (a != 0);
                  wd    = {8'hA0 + n[7:0], 8'h0F ^ n[7:0]};
                  rd    = {8'h5A ^ n[7:0], 8'h30 + n[7:0]};
                  n++;
                  access(~own, g[0], enV, cardV, w[0], a[0], rw[0], wd, rd, exp,
                         rw != 0 ? "R5 R2 R3 R4 R7 sweep write" : "R6 R2 R3 R4 R7 sweep read");
                end

    // R8: inputs change after the decision edge, steered access stays steered
    @(negedge clk);
    globalEn = 1'b1; csEn = '0; cardMode = '0; widthN = 1'b0; addr0 = 1'b1;
    cpuWrData = 16'hC35A; csN = 5'b11110;
    @(negedge clk);
    widthN = 1'b1; addr0 = 1'b0; globalEn = 1'b0; weN = 1'b0;
    #1;
    checkWrite("R8 held steer after change", 16'hC35A, 1'b1);
    endAccess();

    // R8: non-steered access stays non-steered
    @(negedge clk);
    globalEn = 1'b0; csEn = '0; widthN = 1'b1; addr0 = 1'b0;
    devRdData = 16'h7E81; csN = 5'b11101;
    @(negedge clk);
    globalEn = 1'b1; widthN = 1'b0; addr0 = 1'b1; oeN = 1'b0;
    #1;
    checkRead("R8 held pass after change", 16'h7E81, 1'b0);
    endAccess();

    // R8 R10: second strobe in the same select window keeps decision, gated by strobe
    @(negedge clk);
    globalEn = 1'b1; widthN = 1'b0; addr0 = 1'b1; cpuWrData = 16'h9966;
    devRdData = 16'h4411; csN = 5'b11011;
    @(negedge clk);
    weN = 1'b0;
    #1;
    checkWrite("R10 first strobe", 16'h9966, 1'b1);
    @(negedge clk);
    weN = 1'b1;
    #1;
    check("R10 steerWr drops with strobe", {31'd0, steerWr}, 32'd0);
    check("R10 passes between strobes", {16'd0, devWrData}, {16'd0, 16'h9966});
    @(negedge clk);
    oeN = 1'b0;
    #1;
    checkRead("R10 read in same window", 16'h4411, 1'b1);
    endAccess();

    // R9: strobe already low when the select is first seen
    @(negedge clk);
    globalEn = 1'b1; widthN = 1'b0; addr0 = 1'b1; cpuWrData = 16'h1F2E;
    csN = 5'b11110; weN = 1'b0;
    @(negedge clk);
    #1;
    checkWrite("R9 late select", 16'h1F2E, 1'b0);
    @(negedge clk);
    #1;
    checkWrite("R9 still not steered", 16'h1F2E, 1'b0);
    endAccess();

    // R11: two selects low, lowest decides
    access(5'b01101, 1'b0, 5'b00010, 5'b00000, 1'b0, 1'b1, 1'b1, 16'hD00D, 16'h0,
           1'b1, "R11 lowest select enabled");
    access(5'b01101, 1'b0, 5'b10000, 5'b00000, 1'b0, 1'b1, 1'b0, 16'h0, 16'h8C3B,
           1'b0, "R11 higher select ignored");
    access(5'b00111, 1'b1, 5'b00000, 5'b01000, 1'b0, 1'b1, 1'b1, 16'h6A95, 16'h0,
           1'b0, "R11 R3 card on lowest select");

    // R1: released, back to pass-through
    @(negedge clk);
    weN = 1'b0; oeN = 1'b0; cpuWrData = 16'h0FF0; devRdData = 16'hA55A;
    #1;
    checkWrite("R1 idle after accesses", 16'h0FF0, 1'b0);
    checkRead("R1 idle after accesses", 16'hA55A, 1'b0);
    @(negedge clk);
    weN = 1'b1; oeN = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule